// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is an 8 KB data cache placed between a processor that issues 32-bit word loads and stores and a lower memory that moves whole 32-byte lines, one 32-bit beat at a time. Each set holds two lines. A lookup reads both tag entries of the indexed set at once, compares them with the request tag in parallel and steers the word from whichever way matched. When both ways of a set are valid, a miss replaces the way that was used least recently.

Stores that hit change only the cached line and mark it modified. Stores that miss first fetch the line and then merge the word into it. A modified line goes back to memory only when it is chosen for replacement, and that write-back always finishes before the refill that replaces it starts. The processor holds its request steady until `cpu_done_o` rises. On a hit this happens in the same cycle. On a miss it is held low for the whole memory sequence.

Top module: `cache_2way_wb`

## Requirements
- R1: A load that misses returns the memory word chosen by address bits [4:2]. The 34-bit byte address splits into tag [33:12], set index [11:5], word within the line [4:2] and ignored bits [1:0]. The line address on the memory port is bits [33:5].
- R2: Two lines with different tags and the same set index are both held, and later accesses to either one hit.
- R3: When both ways of the set are valid, a miss replaces the way that was used least recently.
- R4: A store that hits completes in its request cycle with no memory traffic. A later load returns the stored word, and the line is marked modified.
- R5: A store that misses refills the line and then merges the word. A later load returns the stored word, the other words come from memory, and the line is marked modified.
- R6: Replacing a modified line first writes its eight beats to the victim's line address (victim tag with set index), in beat order 0 to 7, holding that address steady. The eight refill reads follow. Read and write are never requested together.
- R7: Replacing an unmodified line issues no memory writes.
- R8: With `mem_ack_i` high on every request cycle, `cpu_done_o` rises after 0 cycles on a hit, 9 cycles on a clean miss and 17 cycles on a dirty miss. It is never high while memory is being accessed.
- R9: After reset every line is invalid, no memory request is active and `cpu_done_o` is low.
- R10: A hit makes the other way of its set the next victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Access request, held until done |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 34 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_rdata_o | output | 32 | Load data, valid with done |
| cpu_done_o | output | 1 | Access completes this cycle |
| mem_rd_o | output | 1 | Refill beat request |
| mem_wr_o | output | 1 | Write-back beat request |
| mem_blk_o | output | 29 | Line address of the transfer |
| mem_beat_o | output | 3 | Word index within the line |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Refill data, valid with ack |
| mem_ack_i | input | 1 | Beat accepted or returned |

## Verification
The bench targets victim choice at the edges of the replacement state. A set that is touched again before a third tag arrives must lose its other line. A design that ignores hits when updating its LRU state would throw out the line that was just used, and the next access to that line would then be reported as a slow miss. Dirty lines made by store hits and by allocating store misses are later evicted. The bench checks the write-back address and the merged word, so a missing dirty bit, a lost merge or a refill that runs before the write-back shows up as wrong beat counts or wrong data. Stall lengths for hits, clean misses and dirty misses are counted exactly, so an extra or missing state in the miss sequence is caught.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int WAYS = 2;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } miss_st_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_dirty,
  input  logic [LINE_W-1:0] wr_line,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  // state bits: reset clears every line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // storage arrays carry no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_line  = line_mem[rd_idx];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_used_way
);
  localparam int SETS = 1 << IDX_W;

  // one bit per set: names the way to replace next
  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (upd_en) lru_d[upd_idx] = ~upd_used_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign rd_victim = lru_q[rd_idx];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int WORD_W = 32,
  parameter int BEAT_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  input  logic                         hit_i,
  input  logic                         vict_way_i,
  input  logic                         vict_dirty_i,
  input  logic                         ack_i,
  input  logic [WORD_W-1:0]            rdata_i,
  output miss_st_e                     st_o,
  output logic [BEAT_W-1:0]            beat_o,
  output logic [ADDR_W-1:0]            lat_addr_o,
  output logic                         lat_we_o,
  output logic [WORD_W-1:0]            lat_wdata_o,
  output logic                         lat_vway_o,
  output logic [(1<<BEAT_W)*WORD_W-1:0] fill_buf_o
);
  localparam int BEATS = 1 << BEAT_W;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  miss_st_e          st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              cap_en;
  logic              buf_en;
  logic [BEATS-1:0][WORD_W-1:0] buf_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic              vway_q;

  assign cap_en = (st_q == ST_IDLE) && req_i && !hit_i;
  assign buf_en = (st_q == ST_FILL) && ack_i;

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cap_en) begin
          st_d   = vict_dirty_i ? ST_WBACK : ST_FILL;
          beat_d = '0;
        end
      end
      ST_WBACK: begin
        if (ack_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (ack_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST) st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  // request capture, enabled on a miss
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      wdata_q <= wdata_i;
      vway_q  <= vict_way_i;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_en) buf_q[beat_q] <= rdata_i;
  end

  assign st_o        = st_q;
  assign beat_o      = beat_q;
  assign lat_addr_o  = addr_q;
  assign lat_we_o    = we_q;
  assign lat_wdata_o = wdata_q;
  assign lat_vway_o  = vway_q;
  assign fill_buf_o  = buf_q;
endmodule

// File: rtl/cache_2way_wb.sv
module cache_2way_wb
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 7,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int BEAT_W = OFF_W - 2,
  localparam int BEATS  = 1 << BEAT_W,
  localparam int LINE_W = BEATS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              cpu_done_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BLK_W-1:0]  mem_blk_o,
  output logic [BEAT_W-1:0] mem_beat_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  miss_st_e          st;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_we;
  logic [WORD_W-1:0] lat_wdata;
  logic              lat_vway;
  logic [BEATS-1:0][WORD_W-1:0] fill_buf;

  logic              idle, fill_now;
  logic [ADDR_W-1:0] look_addr;
  logic [TAG_W-1:0]  look_tag;
  logic [IDX_W-1:0]  look_idx;
  logic [BEAT_W-1:0] look_off;
  logic              unused_lsb;

  assign idle      = (st == ST_IDLE);
  assign fill_now  = (st == ST_DONE);
  assign look_addr = idle ? cpu_addr_i : lat_addr;
  assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
  assign look_idx  = look_addr[OFF_W +: IDX_W];
  assign look_off  = look_addr[OFF_W-1:2];
  assign unused_lsb = ^look_addr[1:0];

  // per-way lookup, compared in parallel
  logic [WAYS-1:0]   way_v, way_d, way_hit, way_we;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [BEATS-1:0][WORD_W-1:0] way_line [WAYS];
  logic [TAG_W-1:0]  wr_tag;
  logic              wr_dirty;
  logic [BEATS-1:0][WORD_W-1:0] wr_line;
  logic              hit, hit_way, hit_store, hit_any;
  logic              lru_victim, vict_way, vict_dirty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache2w_way #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
    ) i_way (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .rd_idx  (look_idx),
      .wr_en   (way_we[w]),
      .wr_idx  (look_idx),
      .wr_tag  (wr_tag),
      .wr_dirty(wr_dirty),
      .wr_line (wr_line),
      .rd_valid(way_v[w]),
      .rd_dirty(way_d[w]),
      .rd_tag  (way_tag[w]),
      .rd_line (way_line[w])
    );
    assign way_hit[w] = way_v[w] && (way_tag[w] == look_tag);
    assign way_we[w]  = (hit_store && (hit_way == 1'(w))) ||
                        (fill_now && (lat_vway == 1'(w)));
  end

  assign hit       = |way_hit;
  assign hit_way   = way_hit[1];
  assign hit_any   = idle && cpu_req_i && hit;
  assign hit_store = hit_any && cpu_we_i;

  // victim: invalid way first (way 0 before way 1), else LRU
  always_comb begin
    if (!way_v[0])      vict_way = 1'b0;
    else if (!way_v[1]) vict_way = 1'b1;
    else                vict_way = lru_victim;
  end
  assign vict_dirty = way_v[vict_way] && way_d[vict_way];

  cache2w_lru #(.IDX_W(IDX_W)) i_lru (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_idx      (look_idx),
    .rd_victim   (lru_victim),
    .upd_en      (hit_any || fill_now),
    .upd_idx     (look_idx),
    .upd_used_way(fill_now ? lat_vway : hit_way)
  );

  cache2w_ctrl #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .BEAT_W(BEAT_W)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_i       (cpu_req_i),
    .we_i        (cpu_we_i),
    .addr_i      (cpu_addr_i),
    .wdata_i     (cpu_wdata_i),
    .hit_i       (hit),
    .vict_way_i  (vict_way),
    .vict_dirty_i(vict_dirty),
    .ack_i       (mem_ack_i),
    .rdata_i     (mem_rdata_i),
    .st_o        (st),
    .beat_o      (beat),
    .lat_addr_o  (lat_addr),
    .lat_we_o    (lat_we),
    .lat_wdata_o (lat_wdata),
    .lat_vway_o  (lat_vway),
    .fill_buf_o  (fill_buf)
  );

  // line to write: merged refill or merged store hit
  always_comb begin
    if (fill_now) begin
      wr_line = fill_buf;
      if (lat_we) wr_line[look_off] = lat_wdata;
      wr_dirty = lat_we;
    end else begin
      wr_line = way_line[hit_way];
      wr_line[look_off] = cpu_wdata_i;
      wr_dirty = 1'b1;
    end
  end
  assign wr_tag = look_tag;

  assign cpu_rdata_o = fill_now ? wr_line[look_off] : way_line[hit_way][look_off];
  assign cpu_done_o  = hit_any || fill_now;

  assign mem_rd_o    = (st == ST_FILL);
  assign mem_wr_o    = (st == ST_WBACK);
  assign mem_beat_o  = beat;
  assign mem_blk_o   = mem_wr_o ? {way_tag[lat_vway], look_idx} : lat_addr[ADDR_W-1:OFF_W];
  assign mem_wdata_o = way_line[lat_vway][beat];
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int BLK_W  = 29,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_done_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              mem_ack_i,
  input logic [BLK_W-1:0]  mem_blk_o,
  input logic [BEAT_W-1:0] mem_beat_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'((1 << BEAT_W) - 1);

  p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  p_wback_before_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && mem_ack_i && mem_beat_o == LAST) |=> (mem_rd_o && mem_beat_o == '0));

  p_wback_blk_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && $past(mem_wr_o)) |-> $stable(mem_blk_o));

  p_fill_beat_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o) && $past(mem_ack_i)) |-> (mem_beat_o == $past(mem_beat_o) + 1'b1));

  p_fill_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mem_ack_i && mem_beat_o == LAST) |=> (cpu_done_o && !mem_rd_o));

  p_done_mem_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |-> (!mem_rd_o && !mem_wr_o));
endmodule

bind cache_2way_wb cache2w_chk #(
  .BLK_W (BLK_W),
  .BEAT_W(BEAT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_done_o(cpu_done_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .mem_ack_i (mem_ack_i),
  .mem_blk_o (mem_blk_o),
  .mem_beat_o(mem_beat_o)
);

// File: tb/test_cache_2way_wb.sv
module test_cache_2way_wb;
  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [33:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_done;
  logic        mem_rd, mem_wr, mem_ack;
  logic [28:0] mem_blk;
  logic [2:0]  mem_beat;
  logic [31:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int wr_beats = 0;
  int rd_beats = 0;
  logic [28:0] wb_blk;
  logic [31:0] wb_word [8];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cache_2way_wb i_cache_2way_wb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req_i  (cpu_req),
    .cpu_we_i   (cpu_we),
    .cpu_addr_i (cpu_addr),
    .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata),
    .cpu_done_o (cpu_done),
    .mem_rd_o   (mem_rd),
    .mem_wr_o   (mem_wr),
    .mem_blk_o  (mem_blk),
    .mem_beat_o (mem_beat),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .mem_ack_i  (mem_ack)
  );

  // memory model: fixed content, answers every beat at once
  function automatic logic [31:0] pat(input logic [28:0] blk, input logic [2:0] w);
    return {blk, w} ^ 32'h3C3C_C3C3;
  endfunction

  function automatic logic [33:0] mk(input logic [21:0] t, input logic [6:0] i, input logic [2:0] w);
    return {t, i, w, 2'b00};
  endfunction

  assign mem_ack   = mem_rd | mem_wr;
  assign mem_rdata = pat(mem_blk, mem_beat);

  always @(posedge clk) begin
    if (mem_wr && mem_ack) begin
      wb_word[mem_beat] <= mem_wdata;
      wb_blk   <= mem_blk;
      wr_beats <= wr_beats + 1;
    end
    if (mem_rd && mem_ack) rd_beats <= rd_beats + 1;
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [33:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    waits = 0;
    #1;
    while (!cpu_done && waits < 64) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    #1;
  endtask

  // R9, R1, R7, R8: reset state, then a clean load miss
  task automatic t_reset_and_load();
    logic [31:0] d; int wt; int w0, r0;
    chk(!mem_rd && !mem_wr, "R9", "memory idle after reset", {mem_rd, mem_wr}, 0);
    chk(!cpu_done, "R9", "done low after reset", cpu_done, 0);
    w0 = wr_beats; r0 = rd_beats;
    access(1'b0, mk(22'h00ABC, 7'd3, 3'd5), '0, d, wt);
    chk(wt == 9, "R8", "clean miss stall", wt, 9);
    chk(d == pat({22'h00ABC, 7'd3}, 3'd5), "R1", "load miss data", d, pat({22'h00ABC, 7'd3}, 3'd5));
    chk(rd_beats - r0 == 8, "R1", "refill beats", rd_beats - r0, 8);
    chk(wr_beats == w0, "R7", "no write on empty-set miss", wr_beats - w0, 0);
  endtask

  // R2: two tags in one set coexist
  task automatic t_two_way();
    logic [31:0] d; int wt;
    access(1'b0, mk(22'h00011, 7'd5, 3'd2), '0, d, wt);
    access(1'b0, mk(22'h00022, 7'd5, 3'd2), '0, d, wt);
    chk(wt == 9, "R2", "second tag misses", wt, 9);
    access(1'b0, mk(22'h00011, 7'd5, 3'd7), '0, d, wt);
    chk(wt == 0, "R8", "hit stall", wt, 0);
    chk(d == pat({22'h00011, 7'd5}, 3'd7), "R2", "first tag hit data", d, pat({22'h00011, 7'd5}, 3'd7));
    access(1'b0, mk(22'h00022, 7'd5, 3'd0), '0, d, wt);
    chk(wt == 0, "R2", "second tag still hits", wt, 0);
    chk(d == pat({22'h00022, 7'd5}, 3'd0), "R2", "second tag hit data", d, pat({22'h00022, 7'd5}, 3'd0));
  endtask

  // R3, R10: hit refreshes, third tag evicts the other one
  task automatic t_lru();
    logic [31:0] d; int wt; int w0;
    access(1'b0, mk(22'h00101, 7'd9, 3'd0), '0, d, wt);
    access(1'b0, mk(22'h00202, 7'd9, 3'd0), '0, d, wt);
    access(1'b0, mk(22'h00101, 7'd9, 3'd1), '0, d, wt);
    chk(wt == 0, "R10", "refresh hit", wt, 0);
    w0 = wr_beats;
    access(1'b0, mk(22'h00303, 7'd9, 3'd4), '0, d, wt);
    chk(wt == 9, "R3", "third tag clean miss", wt, 9);
    chk(wr_beats == w0, "R7", "clean victim no write", wr_beats - w0, 0);
    chk(d == pat({22'h00303, 7'd9}, 3'd4), "R3", "third tag data", d, pat({22'h00303, 7'd9}, 3'd4));
    access(1'b0, mk(22'h00101, 7'd9, 3'd2), '0, d, wt);
    chk(wt == 0, "R10", "recently used tag kept", wt, 0);
    access(1'b0, mk(22'h00202, 7'd9, 3'd2), '0, d, wt);
    chk(wt == 9, "R3", "least recent tag evicted", wt, 9);
    access(1'b0, mk(22'h00101, 7'd9, 3'd3), '0, d, wt);
    chk(wt == 0, "R3", "refreshed tag survives second eviction", wt, 0);
  endtask

  // R4, R6, R8: store hit then dirty eviction
  task automatic t_store_hit_evict();
    logic [31:0] d; int wt; int w0, r0;
    access(1'b0, mk(22'h01234, 7'd20, 3'd0), '0, d, wt);
    w0 = wr_beats; r0 = rd_beats;
    access(1'b1, mk(22'h01234, 7'd20, 3'd3), 32'hCAFE_0003, d, wt);
    chk(wt == 0, "R4", "store hit stall", wt, 0);
    chk(wr_beats == w0 && rd_beats == r0, "R4", "store hit memory beats",
        (wr_beats - w0) + (rd_beats - r0), 0);
    access(1'b0, mk(22'h01234, 7'd20, 3'd3), '0, d, wt);
    chk(d == 32'hCAFE_0003, "R4", "load after store hit", d, 32'hCAFE_0003);
    access(1'b0, mk(22'h02345, 7'd20, 3'd1), '0, d, wt);
    chk(wt == 9, "R7", "fill into empty way is clean", wt, 9);
    w0 = wr_beats; r0 = rd_beats;
    access(1'b0, mk(22'h03456, 7'd20, 3'd6), '0, d, wt);
    chk(wt == 17, "R8", "dirty miss stall", wt, 17);
    chk(wr_beats - w0 == 8, "R6", "write-back beats", wr_beats - w0, 8);
    chk(rd_beats - r0 == 8, "R6", "refill after write-back", rd_beats - r0, 8);
    chk(wb_blk == {22'h01234, 7'd20}, "R6", "write-back line address", wb_blk, {22'h01234, 7'd20});
    chk(wb_word[3] == 32'hCAFE_0003, "R4", "stored word written back", wb_word[3], 32'hCAFE_0003);
    chk(wb_word[0] == pat({22'h01234, 7'd20}, 3'd0), "R6", "untouched word written back",
        wb_word[0], pat({22'h01234, 7'd20}, 3'd0));
    chk(d == pat({22'h03456, 7'd20}, 3'd6), "R6", "data after dirty miss", d, pat({22'h03456, 7'd20}, 3'd6));
  endtask

  // R5: allocating store miss, merge, then dirty eviction
  task automatic t_store_miss();
    logic [31:0] d; int wt; int w0, r0;
    w0 = wr_beats; r0 = rd_beats;
    access(1'b1, mk(22'h0A0A0, 7'd30, 3'd6), 32'h5EED_0006, d, wt);
    chk(wt == 9, "R5", "store miss stall", wt, 9);
    chk(rd_beats - r0 == 8 && wr_beats == w0, "R5", "store miss fetches line",
        rd_beats - r0, 8);
    access(1'b0, mk(22'h0A0A0, 7'd30, 3'd6), '0, d, wt);
    chk(wt == 0 && d == 32'h5EED_0006, "R5", "stored word after allocate", d, 32'h5EED_0006);
    access(1'b0, mk(22'h0A0A0, 7'd30, 3'd1), '0, d, wt);
    chk(d == pat({22'h0A0A0, 7'd30}, 3'd1), "R5", "other word from memory", d, pat({22'h0A0A0, 7'd30}, 3'd1));
    access(1'b0, mk(22'h0B0B0, 7'd30, 3'd0), '0, d, wt);
    w0 = wr_beats;
    access(1'b0, mk(22'h0C0C0, 7'd30, 3'd0), '0, d, wt);
    chk(wr_beats - w0 == 8, "R5", "allocated line is dirty", wr_beats - w0, 8);
    chk(wb_word[6] == 32'h5EED_0006, "R5", "merged word written back", wb_word[6], 32'h5EED_0006);
    chk(wb_blk == {22'h0A0A0, 7'd30}, "R6", "victim address", wb_blk, {22'h0A0A0, 7'd30});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset_and_load();
    t_two_way();
    t_lru();
    t_store_hit_evict();
    t_store_miss();
    report();
    $finish;
  end
endmodule